// File: doc/BRIEF.md
# Privileged Status Register Access Controller

The block holds a processor's 32-bit status register and controls which of its fields move-to and move-from status requests may read or write. The rules depend on the current privilege bit and DSP-enable bit. Supervisor modes have full access. Plain user mode traps every access. DSP user mode reads freely, but its writes change only the repeat and modulo-addressing fields and quietly leave the other fields as they were.

A second write path, used when a repeat loop is set up, loads the repeat counter and the repeat flag fields directly. This path ignores the access rules. Instruction decode, the general register file and exception vectoring are outside the block. They drive the request strobes and data, and they consume the register value, the read data and the illegal-instruction pulse.

Top module: `sr_access_ctrl`

## Requirements
- R1: After reset, sr_o reads 0x700000F0 (privilege, bank and block bits set, interrupt mask 1111, all else 0), rdata_o is 0 and illegal_o is 0.
- R2: When privilege bit 30 is 1, with DSP bit 12 at either value, a write request loads every defined bit of sr_o from wdata_i one cycle later.
- R3: In any mode other than plain user, a read request makes rdata_o equal to the sr_o value of the request cycle, one cycle later. At other times rdata_o holds its value.
- R4: When bits 30 and 12 are both 0, any read or write request leaves sr_o and rdata_o unchanged. It raises illegal_o in the following cycle, and illegal_o drops again in the cycle after that.
- R5: When bit 30 is 0 and bit 12 is 1, a write updates only the repeat counter (27:16), the modulo bits (11:10) and the repeat flags (3:2). All other bits keep their value and illegal_o stays 0.
- R6: The access check for a write uses the mode before that write. A supervisor write that clears bits 30 and 12 is accepted, and the next request is checked in plain user mode.
- R7: A repeat-setup request loads bits 27:16 from rpt_rc_i and bits 3:2 from rpt_rf_i one cycle later in every mode, plain user included, and never raises illegal_o.
- R8: When a repeat-setup request and a write request arrive in the same cycle, bits 27:16 and 3:2 take the repeat-setup values. The other bits follow the write rules of the current mode.
- R9: The field layout is: privilege 30, bank 29, block 28, repeat counter 27:16, DSP enable 12, modulo 11 and 10, M 9, Q 8, interrupt mask 7:4, repeat flags 3:2, S 1, T 0. Bits 31 and 15:13 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stc_req_i | input | 1 | Read request: copy the status register to rdata_o |
| ldc_req_i | input | 1 | Write request: load the status register from wdata_i |
| wdata_i | input | 32 | Write data |
| rpt_req_i | input | 1 | Repeat-setup request |
| rpt_rc_i | input | 12 | Repeat counter value |
| rpt_rf_i | input | 2 | Repeat flag value |
| sr_o | output | 32 | Current status register |
| rdata_o | output | 32 | Read data from the last accepted read |
| illegal_o | output | 1 | Illegal-instruction pulse |

## Verification
Every result comes from one register stage. sr_o, rdata_o and illegal_o all change on the first rising edge after a request, and illegal_o falls on the edge after that. The bench drives each request on a falling edge and removes it on the next falling edge, where it samples all three outputs. To confirm that the trap pulse lasts one cycle, it samples illegal_o again one falling edge later. Because plain user mode can only be left through reset, each scenario begins with its own reset.

// File: rtl/sr_pkg.sv
`timescale 1ns/1ps
package sr_pkg;
  localparam int SR_W  = 32;
  localparam int RC_W  = 12;
  localparam int IM_W  = 4;
  localparam int RF_W  = 2;

  localparam int MD_B  = 30;
  localparam int RB_B  = 29;
  localparam int BL_B  = 28;
  localparam int RC_LO = 16;
  localparam int DSP_B = 12;
  localparam int DMY_B = 11;
  localparam int DMX_B = 10;
  localparam int M_B   = 9;
  localparam int Q_B   = 8;
  localparam int IM_LO = 4;
  localparam int RF_LO = 2;
  localparam int S_B   = 1;
  localparam int T_B   = 0;

  // encoding is {privilege, dsp_enable}
  typedef enum logic [1:0] {
    MODE_USR  = 2'b00,
    MODE_DUSR = 2'b01,
    MODE_SUP  = 2'b10,
    MODE_DSUP = 2'b11
  } mode_e;

  function automatic logic [SR_W-1:0] fmask(int lo, int w);
    logic [SR_W-1:0] m;
    m = '0;
    for (int i = 0; i < SR_W; i++) begin
      if (i >= lo && i < lo + w) m[i] = 1'b1;
    end
    return m;
  endfunction

  localparam logic [SR_W-1:0] RC_M  = fmask(RC_LO, RC_W);
  localparam logic [SR_W-1:0] IM_M  = fmask(IM_LO, IM_W);
  localparam logic [SR_W-1:0] RF_M  = fmask(RF_LO, RF_W);
  localparam logic [SR_W-1:0] CTL_M = fmask(BL_B, 3);
  localparam logic [SR_W-1:0] BIT_M = fmask(DSP_B, 1) | fmask(DMY_B, 1) | fmask(DMX_B, 1)
                                    | fmask(M_B, 1) | fmask(Q_B, 1) | fmask(S_B, 1)
                                    | fmask(T_B, 1);
  localparam logic [SR_W-1:0] DEF_M  = CTL_M | RC_M | IM_M | RF_M | BIT_M;
  localparam logic [SR_W-1:0] DUSR_M = RC_M | fmask(DMY_B, 1) | fmask(DMX_B, 1) | RF_M;
  localparam logic [SR_W-1:0] RPT_M  = RC_M | RF_M;
  localparam logic [SR_W-1:0] RST_V  = CTL_M | IM_M;
endpackage

// File: rtl/sr_mode_dec.sv
`timescale 1ns/1ps
module sr_mode_dec
  import sr_pkg::*;
(
  input  logic            md_i,
  input  logic            dsp_i,
  input  logic            stc_i,
  input  logic            ldc_i,
  output mode_e           mode_o,
  output logic [SR_W-1:0] wmask_o,
  output logic            stc_ok_o,
  output logic            trap_o
);
  logic [SR_W-1:0] lmask;

  assign mode_o = mode_e'({md_i, dsp_i});

  always_comb begin
    unique case (mode_o)
      MODE_SUP, MODE_DSUP: lmask = DEF_M;
      MODE_DUSR:           lmask = DUSR_M;
      default:             lmask = '0;
    endcase
  end

  assign wmask_o  = ldc_i ? lmask : '0;
  assign stc_ok_o = stc_i && (mode_o != MODE_USR);
  assign trap_o   = (stc_i || ldc_i) && (mode_o == MODE_USR);
endmodule

// File: rtl/sr_merge.sv
`timescale 1ns/1ps
module sr_merge
  import sr_pkg::*;
(
  input  logic [SR_W-1:0] sr_i,
  input  logic [SR_W-1:0] wdata_i,
  input  logic [SR_W-1:0] wmask_i,
  input  logic            rpt_i,
  input  logic [RC_W-1:0] rpt_rc_i,
  input  logic [RF_W-1:0] rpt_rf_i,
  output logic [SR_W-1:0] sr_o
);
  logic [SR_W-1:0] ldc_v;
  logic [SR_W-1:0] rpt_v;

  assign ldc_v = (sr_i & ~wmask_i) | (wdata_i & wmask_i);

  always_comb begin
    rpt_v = '0;
    rpt_v[RC_LO +: RC_W] = rpt_rc_i;
    rpt_v[RF_LO +: RF_W] = rpt_rf_i;
  end

  // repeat setup overrides the write path on its fields
  assign sr_o = (rpt_i ? ((ldc_v & ~RPT_M) | rpt_v) : ldc_v) & DEF_M;
endmodule

// File: rtl/sr_access_ctrl.sv
`timescale 1ns/1ps
module sr_access_ctrl
  import sr_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stc_req_i,
  input  logic            ldc_req_i,
  input  logic [SR_W-1:0] wdata_i,
  input  logic            rpt_req_i,
  input  logic [RC_W-1:0] rpt_rc_i,
  input  logic [RF_W-1:0] rpt_rf_i,
  output logic [SR_W-1:0] sr_o,
  output logic [SR_W-1:0] rdata_o,
  output logic            illegal_o
);
  logic [SR_W-1:0] sr_q, sr_d, rdata_q, wmask;
  logic            illegal_q, stc_ok, trap;
  mode_e           mode;

  sr_mode_dec u_dec (
    .md_i    (sr_q[MD_B]),
    .dsp_i   (sr_q[DSP_B]),
    .stc_i   (stc_req_i),
    .ldc_i   (ldc_req_i),
    .mode_o  (mode),
    .wmask_o (wmask),
    .stc_ok_o(stc_ok),
    .trap_o  (trap)
  );

  sr_merge u_merge (
    .sr_i    (sr_q),
    .wdata_i (wdata_i),
    .wmask_i (wmask),
    .rpt_i   (rpt_req_i),
    .rpt_rc_i(rpt_rc_i),
    .rpt_rf_i(rpt_rf_i),
    .sr_o    (sr_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q      <= RST_V;
      rdata_q   <= '0;
      illegal_q <= 1'b0;
    end else begin
      sr_q      <= sr_d;
      illegal_q <= trap;
      if (stc_ok) rdata_q <= sr_q;
    end
  end

  assign sr_o      = sr_q;
  assign rdata_o   = rdata_q;
  assign illegal_o = illegal_q;

  // R4: plain user writes do not touch the register
  p_user_keep_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sr_o[MD_B] && !sr_o[DSP_B] && ldc_req_i && !rpt_req_i) |=> $stable(sr_o));

  // R4: trap pulse follows an access in plain user mode
  p_user_trap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sr_o[MD_B] && !sr_o[DSP_B] && (ldc_req_i || stc_req_i)) |=> illegal_o);

  // R4: no pulse without an offending request
  p_no_spurious_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !((!sr_o[MD_B] && !sr_o[DSP_B]) && (ldc_req_i || stc_req_i)) |=> !illegal_o);

  // R3: read data is the register of the request cycle
  p_stc_data_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stc_req_i && (sr_o[MD_B] || sr_o[DSP_B])) |=> (rdata_o == $past(sr_o)));

  // R5: protected fields stay put in DSP user mode
  p_dusr_keep_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sr_o[MD_B] && sr_o[DSP_B] && ldc_req_i) |=> ((sr_o & ~DUSR_M) == $past(sr_o & ~DUSR_M)));

  // R7, R8: repeat setup values always land
  p_rpt_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpt_req_i |=> (sr_o[RC_LO +: RC_W] == $past(rpt_rc_i) && sr_o[RF_LO +: RF_W] == $past(rpt_rf_i)));

  // R9: reserved bits never set
  p_resv_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sr_o & ~DEF_M) == '0);
endmodule

// File: tb/sr_access_ctrl_tb_top.sv
`timescale 1ns/1ps
module sr_access_ctrl_tb_top;
  logic        clk, rst_n;
  logic        stc, ldc, rpt;
  logic [31:0] wdata;
  logic [11:0] rc;
  logic [1:0]  rf;
  logic [31:0] sr, rdata;
  logic        ill;
  int          total = 0, bad = 0;

  sr_access_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .stc_req_i(stc), .ldc_req_i(ldc), .wdata_i(wdata),
    .rpt_req_i(rpt), .rpt_rc_i(rc), .rpt_rf_i(rf),
    .sr_o(sr), .rdata_o(rdata), .illegal_o(ill)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%08h exp=%08h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    stc = 0; ldc = 0; rpt = 0; wdata = '0; rc = '0; rf = '0;
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  // one request cycle; outputs checked at the following falling edge
  task automatic req(logic s, logic l, logic [31:0] d, logic r, logic [11:0] c, logic [1:0] f);
    @(negedge clk);
    stc = s; ldc = l; wdata = d; rpt = r; rc = c; rf = f;
    @(negedge clk);
    stc = 0; ldc = 0; rpt = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 sr", sr, 32'h7000_00F0);
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 illegal", {31'b0, ill}, 32'h0);
  endtask

  task automatic t_supervisor();
    do_reset();
    req(0, 1, 32'hFFFF_FFFF, 0, 0, 0);
    chk("R2 R9 sup write all", sr, 32'h7FFF_1FFF);
    chk("R2 no trap", {31'b0, ill}, 32'h0);
    req(1, 0, 0, 0, 0, 0);
    chk("R3 sup read", rdata, 32'h7FFF_1FFF);
    req(0, 1, 32'h5000_1234, 0, 0, 0);
    chk("R2 enter dsp sup", sr, 32'h5000_1234);
    req(0, 1, 32'hFFFF_FFFF, 0, 0, 0);
    chk("R2 dsp sup write all", sr, 32'h7FFF_1FFF);
    req(0, 1, 32'h8000_E000, 0, 0, 0);
    chk("R9 reserved bits", sr, 32'h0000_0000);
  endtask

  task automatic t_user_trap();
    do_reset();
    req(1, 0, 0, 0, 0, 0);
    chk("R3 read before drop", rdata, 32'h7000_00F0);
    req(0, 1, 32'h0, 0, 0, 0);
    chk("R6 drop to user accepted", sr, 32'h0);
    chk("R6 no trap on drop", {31'b0, ill}, 32'h0);
    req(0, 1, 32'hFFFF_FFFF, 0, 0, 0);
    chk("R4 user write ignored", sr, 32'h0);
    chk("R4 write trap", {31'b0, ill}, 32'h1);
    @(negedge clk);
    chk("R4 pulse one cycle", {31'b0, ill}, 32'h0);
    req(1, 0, 0, 0, 0, 0);
    chk("R4 read trap", {31'b0, ill}, 32'h1);
    chk("R4 rdata kept", rdata, 32'h7000_00F0);
  endtask

  task automatic t_dsp_user();
    do_reset();
    req(0, 1, 32'h0000_1000, 0, 0, 0);
    chk("R6 enter dsp user", sr, 32'h0000_1000);
    req(0, 1, 32'hFFFF_FFFF, 0, 0, 0);
    chk("R5 partial update", sr, 32'h0FFF_1C0C);
    chk("R5 no trap", {31'b0, ill}, 32'h0);
    req(0, 1, 32'h0, 0, 0, 0);
    chk("R5 dsp bit kept", sr, 32'h0000_1000);
    req(1, 0, 0, 0, 0, 0);
    chk("R3 dsp user read", rdata, 32'h0000_1000);
  endtask

  task automatic t_repeat();
    do_reset();
    req(0, 1, 32'h0, 0, 0, 0);
    req(0, 0, 0, 1, 12'hABC, 2'b10);
    chk("R7 repeat in user", sr, 32'h0ABC_0008);
    chk("R7 no trap", {31'b0, ill}, 32'h0);
    do_reset();
    req(0, 1, 32'hFFFF_FFFF, 1, 12'h123, 2'b01);
    chk("R8 sup collision", sr, 32'h7123_1FF7);
    req(0, 1, 32'h0000_1000, 0, 0, 0);
    req(0, 1, 32'hFFFF_FFFF, 1, 12'h055, 2'b00);
    chk("R8 dsp user collision", sr, 32'h0055_1C00);
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_supervisor();
    t_user_trap();
    t_dsp_user();
    t_repeat();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule